// File: doc/BRIEF.md
# Two-Stage System Watchdog

This block is a two-stage watchdog timer. It takes its sense of time from a free-running 64-bit system count supplied at its input. Software programs a timeout period and enables the timer. From then on, software must write the refresh location before each period runs out.

The first missed period raises the warning flag WS0, which is normally routed to an interrupt. If the next period also passes with no refresh, the block raises the reset-request flag WS1. WS1 stays set until the block's own reset. It is also readable as a status bit, so software can tell after a restart that the watchdog caused it.

The registers are split into two frames. The control frame holds control/status, the period (offset) registers, the current compare value and an identification word. The refresh frame holds only the refresh location.

Expiry and refresh are resolved by a small state machine with three states:
- OFF: the timer is disabled.
- ARMED: the timer is running and WS0 is clear.
- WARN: the timer is running and WS0 is set.

The transitions are:
- OFF→ARMED when the timer is enabled.
- ARMED→WARN on expiry.
- WARN→WARN on expiry, which also sets WS1.
- ARMED/WARN→ARMED on a refresh.
- Any state→OFF when the timer is disabled.

A refresh that arrives in the same cycle as an expiry always wins, so a well-timed refresh can never be dropped.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the enable bit, WS0, WS1, the offset and the compare value all read zero.
- R2: While enabled with WS0 clear, once the count input reaches or passes the compare value, WS0 rises on that edge and the compare value becomes that count plus the offset.
- R3: While enabled with WS0 set, an expiry raises WS1. WS1 is cleared only by reset; neither a refresh nor disabling clears it.
- R4: A write to the refresh address (word 8, the refresh frame) takes effect on the following cycle: WS0 clears and the compare value becomes the count seen in that cycle plus the offset.
- R5: When a refresh takes effect in the same cycle as an expiry, the refresh wins. WS0 ends clear, WS1 is not raised, and the compare value is reloaded from the count plus the offset.
- R6: The enable bit is bit 0 of control word 0. While it is clear, WS0 and WS1 cannot rise, WS0 is held clear and the compare value holds. Writing it from 0 to 1 reloads the compare value on the following cycle.
- R7: A write to either offset word (word 1 for the low 32 bits, word 2 for the high bits) acts as a refresh, with the same timing as R4.
- R8: The identification word (word 5) returns the architecture version in bits [19:16] and an 11-bit implementer code in bits [10:0], with zeros elsewhere.
- R9: With architecture version 0 the offset is 32 bits and word 2 is ignored and reads zero. With any later version the offset is 48 bits and word 2 holds bits [47:32], returned in bits [15:0].
- R10: Control word 0 reads enable in bit 0, WS0 in bit 1 and WS1 in bit 2. Words 3 and 4 read the low and high halves of the compare value. Reads have no side effects, and unmapped words read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_cnt | input | 64 | Free-running system count |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Word address; bit 3 selects the refresh frame |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| ws0 | output | 1 | First-stage warning level |
| ws1 | output | 1 | Second-stage reset-request level |

## Verification
The bench times a refresh so that its reload cycle lands exactly on the count where the compare value expires. It does this once with WS0 clear and once with WS0 set. A design that let the expiry win would keep WS0 raised in the first case and raise WS1 in the second.

The bench also checks that WS1 survives both a refresh and a disable. A design that cleared it there would hide the cause of a watchdog reset.

Finally, it exercises offset writes and enable writes as implicit refreshes, along with the width limit of the high offset word. A wrong design there would expire early or hold bits that do not exist.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int CNT_W  = 64;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
    localparam logic [ADDR_W-1:0] A_OFF_LO = 4'h1;
    localparam logic [ADDR_W-1:0] A_OFF_HI = 4'h2;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 4'h3;
    localparam logic [ADDR_W-1:0] A_CMP_HI = 4'h4;
    localparam logic [ADDR_W-1:0] A_IDENT  = 4'h5;
    localparam logic [ADDR_W-1:0] A_KICK   = 4'h8;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_WARN  = 2'd2
    } wd_state_e;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int unsigned  ARCH_VER  = 1,
    parameter logic [10:0]  IMPL_CODE = 11'h35B,
    parameter int           OFF_W     = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ws0_i,
    input  logic              ws1_i,
    input  logic [CNT_W-1:0]  cmp_i,
    output logic              en_o,
    output logic              reload_o,
    output logic [OFF_W-1:0]  offset_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int          HI_W    = (OFF_W > DATA_W) ? OFF_W - DATA_W : 1;
    localparam logic [31:0] ID_WORD = {12'h0, 4'(ARCH_VER), 5'h0, IMPL_CODE};

    logic              en_q;
    logic              reload_q;
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_rd;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            reload_q <= 1'b0;
            lo_q     <= '0;
        end else begin
            reload_q <= 1'b0;
            if (we_i) begin
                case (addr_i)
                    A_CTRL: begin
                        en_q <= wdata_i[0];
                        if (wdata_i[0] && !en_q) reload_q <= 1'b1;
                    end
                    A_OFF_LO: begin
                        lo_q     <= wdata_i;
                        reload_q <= 1'b1;
                    end
                    A_OFF_HI: reload_q <= (OFF_W > DATA_W);
                    A_KICK:   reload_q <= 1'b1;
                    default:  ;
                endcase
            end
        end
    end

    generate
        if (OFF_W > DATA_W) begin : g_wide
            logic [HI_W-1:0] hi_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) hi_q <= '0;
                else if (we_i && addr_i == A_OFF_HI) hi_q <= wdata_i[HI_W-1:0];
            end
            assign offset_o = {hi_q, lo_q};
            assign hi_rd    = DATA_W'(hi_q);
        end else begin : g_narrow
            assign offset_o = lo_q;
            assign hi_rd    = '0;
        end
    endgenerate

    always_comb begin
        case (addr_i)
            A_CTRL:   rdata_o = {29'h0, ws1_i, ws0_i, en_q};
            A_OFF_LO: rdata_o = lo_q;
            A_OFF_HI: rdata_o = hi_rd;
            A_CMP_LO: rdata_o = cmp_i[31:0];
            A_CMP_HI: rdata_o = cmp_i[63:32];
            A_IDENT:  rdata_o = ID_WORD;
            default:  rdata_o = '0;
        endcase
    end

    assign en_o     = en_q;
    assign reload_o = reload_q;

    // R7: an offset write always schedules a refresh
    a_r7_offset_kick: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_OFF_LO) |=> reload_o);
    // R6: enabling from the off state schedules a reload
    a_r6_enable_kick: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == A_CTRL && wdata_i[0] && !en_o) |=> (reload_o && en_o));
endmodule

// File: rtl/wdog_stage_fsm.sv
module wdog_stage_fsm
    import wdog_pkg::*;
#(
    parameter int OFF_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic             en_i,
    input  logic             reload_i,
    input  logic [OFF_W-1:0] offset_i,
    output logic             ws0_o,
    output logic             ws1_o,
    output logic [CNT_W-1:0] cmp_o
);
    wd_state_e        state_q, state_d;
    logic [CNT_W-1:0] cmp_q, cmp_d;
    logic             ws1_q, ws1_d;
    logic             expire;
    logic [CNT_W-1:0] next_cmp;

    assign expire   = (cnt_i >= cmp_q);
    assign next_cmp = cnt_i + CNT_W'(offset_i);

    always_comb begin
        state_d = state_q;
        cmp_d   = cmp_q;
        ws1_d   = ws1_q;
        unique case (state_q)
            ST_OFF: begin
                if (en_i) begin
                    state_d = ST_ARMED;
                    cmp_d   = next_cmp;
                end
            end
            ST_ARMED: begin
                if (!en_i) begin
                    state_d = ST_OFF;
                end else if (reload_i) begin
                    cmp_d = next_cmp;
                end else if (expire) begin
                    state_d = ST_WARN;
                    cmp_d   = next_cmp;
                end
            end
            ST_WARN: begin
                if (!en_i) begin
                    state_d = ST_OFF;
                end else if (reload_i) begin
                    state_d = ST_ARMED;
                    cmp_d   = next_cmp;
                end else if (expire) begin
                    ws1_d = 1'b1;
                    cmp_d = next_cmp;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cmp_q   <= '0;
            ws1_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cmp_q   <= cmp_d;
            ws1_q   <= ws1_d;
        end
    end

    always_comb begin
        ws0_o = (state_q == ST_WARN);
        ws1_o = ws1_q;
        cmp_o = cmp_q;
    end

    // R3: the reset request is sticky
    a_r3_ws1_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ws1_o |=> ws1_o);
    // R3: the second stage only follows the first
    a_r3_ws1_after_ws0: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ws1_o) |-> $past(ws0_o));
    // R5: a refresh beats a coincident expiry
    a_r5_kick_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && reload_i) |=> !ws0_o);
    // R6: a disabled timer stays quiet and holds its compare value
    a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !ws0_o);
    a_r6_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cmp_o));
    // R2: the warning rises only on an unrefreshed expiry
    a_r2_warn_needs_expiry: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ws0_o) |-> $past(en_i && !reload_i && (cnt_i >= cmp_o)));
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int unsigned ARCH_VER  = 1,
    parameter logic [10:0] IMPL_CODE = 11'h35B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_cnt,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              ws0,
    output logic              ws1
);
    localparam int OFF_W = (ARCH_VER == 0) ? 32 : 48;

    logic             en;
    logic             reload;
    logic [OFF_W-1:0] offset;
    logic [CNT_W-1:0] cmp;

    wdog_regs #(
        .ARCH_VER (ARCH_VER),
        .IMPL_CODE(IMPL_CODE),
        .OFF_W    (OFF_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (reg_we),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata),
        .ws0_i   (ws0),
        .ws1_i   (ws1),
        .cmp_i   (cmp),
        .en_o    (en),
        .reload_o(reload),
        .offset_o(offset),
        .rdata_o (reg_rdata)
    );

    wdog_stage_fsm #(
        .OFF_W(OFF_W)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_i   (sys_cnt),
        .en_i    (en),
        .reload_i(reload),
        .offset_i(offset),
        .ws0_o   (ws0),
        .ws1_o   (ws1),
        .cmp_o   (cmp)
    );
endmodule

// File: tb/wdog_two_stage_tb.sv
module wdog_two_stage_tb;
    import wdog_pkg::*;

    localparam logic [10:0] IMPL = 11'h35B;
    localparam logic [31:0] ID_EXP = {12'h0, 4'd1, 5'h0, IMPL};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt = 64'd100;
    logic        we = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = 32'h0;
    logic [31:0] rdata;
    logic        ws0, ws1;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // model state
    bit          m_en, m_rel, m_ws0, m_ws1;
    logic [63:0] m_off, m_cmp;

    always #4 clk = ~clk;

    wdog_two_stage #(.ARCH_VER(1), .IMPL_CODE(IMPL)) u_dut (
        .clk(clk), .rst_n(rst_n), .sys_cnt(cnt), .reg_we(we), .reg_addr(addr),
        .reg_wdata(wdata), .reg_rdata(rdata), .ws0(ws0), .ws1(ws1)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_read(logic [3:0] a);
        case (a)
            4'h0:    return {29'h0, m_ws1, m_ws0, m_en};
            4'h1:    return m_off[31:0];
            4'h2:    return {16'h0, m_off[47:32]};
            4'h3:    return m_cmp[31:0];
            4'h4:    return m_cmp[63:32];
            4'h5:    return ID_EXP;
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 0; m_rel = 0; m_ws0 = 0; m_ws1 = 0; m_off = 0; m_cmp = 0;
        end else begin
            if (!m_en) begin
                m_ws0 = 0;
            end else if (m_rel) begin
                m_ws0 = 0;
                m_cmp = cnt + m_off;
            end else if (cnt >= m_cmp) begin
                if (m_ws0) m_ws1 = 1;
                m_ws0 = 1;
                m_cmp = cnt + m_off;
            end
            m_rel = 0;
            if (we) begin
                if (addr == 4'h0) begin
                    if (wdata[0] && !m_en) m_rel = 1;
                    m_en = wdata[0];
                end else if (addr == 4'h1) begin
                    m_off[31:0] = wdata; m_rel = 1;
                end else if (addr == 4'h2) begin
                    m_off[47:32] = wdata[15:0]; m_rel = 1;
                end else if (addr == 4'h8) begin
                    m_rel = 1;
                end
            end
        end
        #1;
        if (!done) begin
            check("R2 ws0 level", ws0, m_ws0);
            check("R3 ws1 level", ws1, m_ws1);
            check("R10 rdata", rdata, m_read(addr));
        end
    end

    task automatic cyc(bit w, logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        cnt = cnt + 1;
        we = w; addr = a; wdata = d;
    endtask

    task automatic idle(int n);
        repeat (n) cyc(0, 4'h0, 32'h0);
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] v);
        cyc(0, a, 32'h0);
        #1 v = rdata;
    endtask

    task automatic flags(string tag, bit e0, bit e1);
        #1;
        check({tag, " ws0"}, ws0, e0);
        check({tag, " ws1"}, ws1, e1);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; we = 0; addr = 0; wdata = 0;
        idle(2);
        rst_n = 1;
    endtask

    // Times a refresh so its reload lands on the expiry count
    task automatic race(string tag);
        logic [31:0] lo, hi;
        logic [63:0] c;
        rd(4'h3, lo);
        rd(4'h4, hi);
        c = {hi, lo};
        while (cnt + 1 != c - 1) cyc(0, 4'h0, 32'h0);
        cyc(1, 4'h8, 32'h0);
        cyc(0, 4'h0, 32'h0);
        rd(4'h3, lo);
        check({tag, " compare reloaded"}, lo, 32'(c + 30));
        flags(tag, 0, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL R1 watchdog expired");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [63:0] x;
        idle(3);
        rst_n = 1;
        idle(2);
        // R1 reset state
        rd(4'h0, v); check("R1 ctrl", v, 0);
        rd(4'h1, v); check("R1 offset", v, 0);
        rd(4'h3, v); check("R1 compare", v, 0);
        flags("R1", 0, 0);
        // R8 identification
        rd(4'h5, v); check("R8 ident", v, ID_EXP);
        // R9 high offset width
        cyc(1, 4'h2, 32'hFFFF_FFFF);
        rd(4'h2, v); check("R9 offset high", v, 32'h0000_FFFF);
        cyc(1, 4'h2, 32'h0);
        // R2/R3 escalation with offset 20
        cyc(1, 4'h1, 32'd20);
        cyc(1, 4'h0, 32'h1);
        idle(25);
        flags("R2 first expiry", 1, 0);
        idle(25);
        flags("R3 second expiry", 1, 1);
        cyc(1, 4'h8, 32'h0);
        idle(3);
        flags("R3 sticky after refresh R4", 0, 1);
        cyc(1, 4'h0, 32'h0);
        idle(2);
        flags("R3 sticky after disable", 0, 1);
        rd(4'h0, v); check("R10 ctrl layout", v, 32'h4);
        do_reset();
        idle(1);
        flags("R1 after reset", 0, 0);
        // R4 periodic refresh keeps timer quiet
        cyc(1, 4'h1, 32'd30);
        cyc(1, 4'h0, 32'h1);
        for (int i = 0; i < 6; i++) begin
            idle(15);
            cyc(1, 4'h8, 32'h0);
        end
        x = cnt;
        idle(1);
        rd(4'h3, v); check("R4 compare after refresh", v, 32'(x + 1 + 30));
        flags("R4 refreshed", 0, 0);
        // R5 race with WS0 clear
        race("R5 race armed");
        // R5 race with WS0 set
        idle(35);
        flags("R2 expiry before race", 1, 0);
        race("R5 race warned");
        idle(10);
        flags("R5 no escalation", 0, 0);
        // R6 disable while warned
        idle(35);
        flags("R6 warned before disable", 1, 0);
        cyc(1, 4'h0, 32'h0);
        idle(2);
        flags("R6 disable clears", 0, 0);
        idle(100);
        flags("R6 disabled quiet", 0, 0);
        // R7 offset write acts as refresh
        cyc(1, 4'h0, 32'h1);
        idle(25);
        cyc(1, 4'h1, 32'd30);
        idle(25);
        flags("R7 offset refresh", 0, 0);
        idle(10);
        flags("R7 expiry after offset refresh", 1, 0);
        idle(2);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule